// File: doc/BRIEF.md
# Accumulator Register-File Execute Unit

This block is the execute stage of a small 8-bit accumulator machine. Each cycle in which the valid strobe is high it takes one decoded instruction and runs it against a working register and a 128-entry byte register file. The subset covers addition and bitwise AND with a literal or with a register operand, forcing a single register bit low or high, and two bit-test forms that can cancel the instruction after them.

For register-operand arithmetic a destination-select input steers the result either into the working register or back into the addressed register. A taken bit test raises a pending-skip state. The next valid instruction is then swallowed as a no-operation, so the test costs two issue slots. The working register, the three status flags and the skip state are registered outputs. A combinational debug port reads any register-file entry so that its contents can be observed.

Top module: `acc_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears the working register, the C, DC and Z flags, the skip state and all 128 register-file entries to zero.
- R2: Opcode 0 (add literal) writes W+k into W on the clock edge. C is set on a carry out of bit 7, DC is set on a carry out of bit 3, and Z is set when the 8-bit sum is zero.
- R3: Opcode 1 (add register) forms W+f. With destination bit 0 the sum goes to W, and with destination bit 1 it goes to register f. C, DC and Z are updated as in R2 in both cases.
- R4: Opcode 2 (AND literal) writes W AND k into W and updates only Z. C and DC keep their values.
- R5: Opcode 3 (AND register) forms W AND f and steers it by the destination bit as in R3. Only Z is updated.
- R6: Opcode 4 clears bit b of register f and opcode 5 sets it, where b is 0 to 7 with 0 the least significant bit. W and all flags are unchanged.
- R7: Opcode 6 raises the skip state when bit b of register f is 0, and opcode 7 raises it when that bit is 1. Neither changes W, the flags or the register file.
- R8: While the skip state is high, the next valid instruction changes no register, no W and no flag, and the skip state returns low.
- R9: A cycle with the valid strobe low changes nothing, and a pending skip stays pending.
- R10: The debug data output shows the register-file entry selected by the debug address in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Opcode (0 to 7, see requirements) |
| in_addr | input | 7 | Register-file address f |
| in_dst | input | 1 | Destination select: 0 for W, 1 for register f |
| in_bit | input | 3 | Bit index b |
| in_lit | input | 8 | Literal k |
| w_out | output | 8 | Working register |
| flag_c | output | 1 | Carry flag |
| flag_dc | output | 1 | Digit-carry flag |
| flag_z | output | 1 | Zero flag |
| skip_pending | output | 1 | The next valid instruction will be squashed |
| dbg_addr | input | 7 | Debug read address |
| dbg_data | output | 8 | Debug read data |

## Verification
The assertions check on every cycle that reset empties W, the flags and the skip state, and that a squashed or idle cycle leaves W and the flags untouched. They also check that bit operations and tests never touch the flags, that AND operations keep C and DC, and that a pending skip is consumed by exactly one valid instruction. The numeric results cannot be shown by those properties, and the bench scenarios must show them. These results are the sums and carries at the nibble and byte boundaries, the destination steering into the register file, the bit-index selection, and whether a test was taken. The bench compares each of them against a reference model over directed boundary sums and a long random stream.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  typedef enum logic [2:0] {
    OP_ADD_LIT  = 3'd0,
    OP_ADD_REG  = 3'd1,
    OP_AND_LIT  = 3'd2,
    OP_AND_REG  = 3'd3,
    OP_BIT_CLR  = 3'd4,
    OP_BIT_SET  = 3'd5,
    OP_TEST_CLR = 3'd6,
    OP_TEST_SET = 3'd7
  } op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flags_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W),
  localparam int HALF  = DATA_W / 2
) (
  input  op_e                op,
  input  logic               dst,
  input  logic [DATA_W-1:0]  w_val,
  input  logic [DATA_W-1:0]  f_val,
  input  logic [DATA_W-1:0]  lit,
  input  logic [BIT_W-1:0]   bidx,
  output logic [DATA_W-1:0]  result,
  output logic               c_out,
  output logic               dc_out,
  output logic               z_out,
  output logic               upd_cdc,
  output logic               upd_z,
  output logic               wr_w,
  output logic               wr_f,
  output logic               skip_req
);

  logic [DATA_W-1:0] operand;
  logic [DATA_W:0]   sum_full;
  logic [HALF:0]     sum_low;
  logic [DATA_W-1:0] mask;
  logic              sel_bit;

  always_comb begin
    operand  = (op == OP_ADD_LIT || op == OP_AND_LIT) ? lit : f_val;
    sum_full = {1'b0, w_val} + {1'b0, operand};
    sum_low  = {1'b0, w_val[HALF-1:0]} + {1'b0, operand[HALF-1:0]};
    mask     = {{(DATA_W-1){1'b0}}, 1'b1} << bidx;
    sel_bit  = f_val[bidx];
  end

  always_comb begin
    result   = f_val;
    upd_cdc  = 1'b0;
    upd_z    = 1'b0;
    wr_w     = 1'b0;
    wr_f     = 1'b0;
    skip_req = 1'b0;
    unique case (op)
      OP_ADD_LIT: begin
        result  = sum_full[DATA_W-1:0];
        upd_cdc = 1'b1;
        upd_z   = 1'b1;
        wr_w    = 1'b1;
      end
      OP_ADD_REG: begin
        result  = sum_full[DATA_W-1:0];
        upd_cdc = 1'b1;
        upd_z   = 1'b1;
        wr_w    = ~dst;
        wr_f    = dst;
      end
      OP_AND_LIT: begin
        result = w_val & operand;
        upd_z  = 1'b1;
        wr_w   = 1'b1;
      end
      OP_AND_REG: begin
        result = w_val & operand;
        upd_z  = 1'b1;
        wr_w   = ~dst;
        wr_f   = dst;
      end
      OP_BIT_CLR: begin
        result = f_val & ~mask;
        wr_f   = 1'b1;
      end
      OP_BIT_SET: begin
        result = f_val | mask;
        wr_f   = 1'b1;
      end
      OP_TEST_CLR: skip_req = ~sel_bit;
      OP_TEST_SET: skip_req = sel_bit;
      default: ;
    endcase
  end

  assign c_out  = sum_full[DATA_W];
  assign dc_out = sum_low[HALF];
  assign z_out  = (result == '0);

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/acc_skip_ctl.sv
module acc_skip_ctl (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic skip_req,
  output logic exec_en,
  output logic pending
);

  assign exec_en = valid & ~pending;

  always_ff @(posedge clk) begin
    if (rst)           pending <= 1'b0;
    else if (valid)    pending <= pending ? 1'b0 : skip_req;
  end

  // R8
  squash_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && pending) |=> !pending);

  // R9
  idle_keeps_skip_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(pending));

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [2:0]                 in_op,
  input  logic [$clog2(DEPTH)-1:0]   in_addr,
  input  logic                       in_dst,
  input  logic [$clog2(DATA_W)-1:0]  in_bit,
  input  logic [DATA_W-1:0]          in_lit,
  output logic [DATA_W-1:0]          w_out,
  output logic                       flag_c,
  output logic                       flag_dc,
  output logic                       flag_z,
  output logic                       skip_pending,
  input  logic [$clog2(DEPTH)-1:0]   dbg_addr,
  output logic [DATA_W-1:0]          dbg_data
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int BIT_W  = $clog2(DATA_W);

  op_e               op;
  logic [DATA_W-1:0] f_val;
  logic [DATA_W-1:0] result;
  logic              c_n, dc_n, z_n;
  logic              upd_cdc, upd_z, wr_w, wr_f, skip_req;
  logic              exec_en;
  logic [DATA_W-1:0] w_q;
  flags_t            flags_q;

  assign op = op_e'(in_op);

  acc_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (exec_en & wr_f),
    .waddr   (in_addr),
    .wdata   (result),
    .raddr_a (in_addr),
    .rdata_a (f_val),
    .raddr_b (dbg_addr),
    .rdata_b (dbg_data)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (op),
    .dst      (in_dst),
    .w_val    (w_q),
    .f_val    (f_val),
    .lit      (in_lit),
    .bidx     (in_bit[BIT_W-1:0]),
    .result   (result),
    .c_out    (c_n),
    .dc_out   (dc_n),
    .z_out    (z_n),
    .upd_cdc  (upd_cdc),
    .upd_z    (upd_z),
    .wr_w     (wr_w),
    .wr_f     (wr_f),
    .skip_req (skip_req)
  );

  acc_skip_ctl u_skip (
    .clk      (clk),
    .rst      (rst),
    .valid    (in_valid),
    .skip_req (skip_req),
    .exec_en  (exec_en),
    .pending  (skip_pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q     <= '0;
      flags_q <= '0;
    end else if (exec_en) begin
      if (wr_w)    w_q        <= result;
      if (upd_cdc) flags_q.c  <= c_n;
      if (upd_cdc) flags_q.dc <= dc_n;
      if (upd_z)   flags_q.z  <= z_n;
    end
  end

  assign w_out   = w_q;
  assign flag_c  = flags_q.c;
  assign flag_dc = flags_q.dc;
  assign flag_z  = flags_q.z;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (w_out == '0 && !flag_c && !flag_dc && !flag_z && !skip_pending));

  // R8
  squash_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && skip_pending) |=> ($stable(w_out) && $stable(flags_q)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(w_out) && $stable(flags_q)));

  // R6 R7
  bitop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !skip_pending && in_op[2]) |=> ($stable(w_out) && $stable(flags_q)));

  // R4 R5
  and_keeps_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !skip_pending && in_op[2:1] == 2'b01) |=> ($stable(flag_c) && $stable(flag_dc)));

endmodule

// File: tb/test_acc_exec_unit.sv
`timescale 1ns/1ps
module test_acc_exec_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] in_op = '0;
  logic [6:0] in_addr = '0;
  logic       in_dst = 1'b0;
  logic [2:0] in_bit = '0;
  logic [7:0] in_lit = '0;
  logic [7:0] w_out;
  logic       flag_c, flag_dc, flag_z, skip_pending;
  logic [6:0] dbg_addr = '0;
  logic [7:0] dbg_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_rf [128];
  logic [7:0] m_w;
  logic       m_c, m_dc, m_z, m_skip;

  always #2.5 clk = ~clk;

  acc_exec_unit i_acc_exec_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_addr(in_addr), .in_dst(in_dst), .in_bit(in_bit), .in_lit(in_lit),
    .w_out(w_out), .flag_c(flag_c), .flag_dc(flag_dc), .flag_z(flag_z),
    .skip_pending(skip_pending), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] add9(input logic [7:0] a, input logic [7:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic half_carry(input logic [7:0] a, input logic [7:0] b);
    logic [4:0] s;
    s = {1'b0, a[3:0]} + {1'b0, b[3:0]};
    return s[4];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 128; i++) m_rf[i] = '0;
    m_w = '0; m_c = 0; m_dc = 0; m_z = 0; m_skip = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1", "w", w_out, 0);
    chk("R1", "flags", {flag_c, flag_dc, flag_z}, 0);
    chk("R1", "skip", skip_pending, 0);
    for (int i = 0; i < 128; i++) begin
      dbg_addr = 7'(i);
      #0.1;
      chk("R1", "rf entry", dbg_data, 0);
    end
  endtask

  task automatic run(input bit v, input logic [2:0] op, input logic [6:0] a,
                     input bit d, input logic [2:0] b, input logic [7:0] k);
    string tag;
    logic [7:0] f, r;
    logic [8:0] s;
    @(negedge clk);
    in_valid = v; in_op = op; in_addr = a; in_dst = d; in_bit = b; in_lit = k;
    dbg_addr = a;
    f = m_rf[a];
    if (!v) tag = "R9";
    else if (m_skip) begin
      tag = "R8";
      m_skip = 0;
    end else begin
      case (op)
        3'd0: begin tag = "R2"; s = add9(m_w, k);
          m_c = s[8]; m_dc = half_carry(m_w, k); m_z = (s[7:0] == 0); m_w = s[7:0]; end
        3'd1: begin tag = "R3"; s = add9(m_w, f);
          m_c = s[8]; m_dc = half_carry(m_w, f); m_z = (s[7:0] == 0);
          if (d) m_rf[a] = s[7:0]; else m_w = s[7:0]; end
        3'd2: begin tag = "R4"; r = m_w & k; m_z = (r == 0); m_w = r; end
        3'd3: begin tag = "R5"; r = m_w & f; m_z = (r == 0);
          if (d) m_rf[a] = r; else m_w = r; end
        3'd4: begin tag = "R6"; m_rf[a][b] = 1'b0; end
        3'd5: begin tag = "R6"; m_rf[a][b] = 1'b1; end
        3'd6: begin tag = "R7"; m_skip = (f[b] == 1'b0); end
        default: begin tag = "R7"; m_skip = (f[b] == 1'b1); end
      endcase
    end
    @(posedge clk);
    #1;
    chk(tag, "w", w_out, m_w);
    chk(tag, "flags c,dc,z", {flag_c, flag_dc, flag_z}, {m_c, m_dc, m_z});
    chk(tag, "skip", skip_pending, m_skip);
    chk(tag, "rf[addr]", dbg_data, m_rf[a]);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();

    // R2 nibble carry, byte carry and zero
    run(1, 3'd0, 7'd0, 0, 3'd0, 8'h0F);
    run(1, 3'd0, 7'd0, 0, 3'd0, 8'h01);
    run(1, 3'd0, 7'd0, 0, 3'd0, 8'hF0);
    run(1, 3'd0, 7'd0, 0, 3'd0, 8'hFF);
    // R3 steering to register then to W
    run(1, 3'd5, 7'd9, 0, 3'd7, 8'h00);
    run(1, 3'd1, 7'd9, 1, 3'd0, 8'h00);
    run(1, 3'd1, 7'd9, 0, 3'd0, 8'h00);
    // R4 AND keeps carry flags, zero result
    run(1, 3'd0, 7'd0, 0, 3'd0, 8'hC8);
    run(1, 3'd2, 7'd0, 0, 3'd0, 8'h00);
    // R5 AND register, both destinations
    run(1, 3'd0, 7'd0, 0, 3'd0, 8'h3C);
    run(1, 3'd1, 7'd127, 1, 3'd0, 8'h00);
    run(1, 3'd3, 7'd127, 0, 3'd0, 8'h00);
    run(1, 3'd3, 7'd127, 1, 3'd0, 8'h00);
    // R6 every bit position
    for (int i = 0; i < 8; i++) run(1, 3'd5, 7'd64, 0, 3'(i), 8'h00);
    for (int i = 0; i < 8; i += 2) run(1, 3'd4, 7'd64, 0, 3'(i), 8'h00);
    // R7/R8 taken test squashes next, idle keeps skip (R9)
    run(1, 3'd7, 7'd64, 0, 3'd1, 8'h00);
    run(0, 3'd0, 7'd0, 0, 3'd0, 8'h55);
    run(1, 3'd0, 7'd0, 0, 3'd0, 8'h55);
    run(1, 3'd6, 7'd64, 0, 3'd1, 8'h00);
    run(1, 3'd6, 7'd64, 0, 3'd0, 8'h00);
    run(1, 3'd5, 7'd64, 0, 3'd0, 8'h00);
    run(1, 3'd7, 7'd64, 0, 3'd0, 8'h00);
    run(1, 3'd6, 7'd64, 0, 3'd0, 8'h00);

    // R10 debug port follows address with no clock edge
    @(negedge clk);
    in_valid = 0;
    for (int i = 0; i < 128; i += 7) begin
      dbg_addr = 7'(i);
      #0.1;
      chk("R10", "dbg read", dbg_data, m_rf[i]);
    end

    // random stream over a narrow address window
    for (int n = 0; n < 4000; n++) begin
      run(($urandom % 8) != 0, 3'($urandom), 7'($urandom % 12), 1'($urandom),
          3'($urandom), 8'($urandom));
    end

    // R1 reset in the middle with a pending skip and dirty state
    run(1, 3'd0, 7'd0, 0, 3'd0, 8'hA5);
    run(1, 3'd1, 7'd3, 1, 3'd0, 8'h00);
    run(1, 3'd5, 7'd5, 0, 3'd3, 8'h00);
    run(1, 3'd7, 7'd5, 0, 3'd3, 8'h00);
    do_reset();
    for (int n = 0; n < 500; n++) begin
      run(1'b1, 3'($urandom), 7'($urandom), 1'($urandom), 3'($urandom), 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end

endmodule